// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block is a small data cache placed between a processor that issues one-word requests and a plain word-wide memory port. It keeps four ways in every set. Each way holds a line of four words, a tag, a valid flag and a dirty flag. A read hit returns the even/odd pair of adjacent words that holds the requested word. A read miss, or a write-back store miss, picks a victim way. If the victim is dirty, the controller first writes the victim line back to memory. It then fetches the new line word by word and replays the request against the filled line.

The write policy is chosen for each access by an attribute bit that travels with the request, so lines of both kinds share the same array. A write-through store updates a resident copy and always sends the word to memory. It never marks a line dirty and never allocates on a miss. The victim way comes from a single round-robin pointer shared by every set, or from a free-running LFSR when random mode is selected. An invalid way is always taken before either of these is consulted. To get separate instruction and data caches, instance the block twice.

Top module: `set_assoc_cache`

## Requirements
- R1: While `rst` is high and in the first cycle after reset, `rsp_valid` and `mem_req` are low. Every line starts invalid, so the first access to any address misses.
- R2: A read hit raises `rsp_valid` for exactly one cycle, in the cycle after the request is seen in the idle state. `rsp_lo` carries the word at the requested word offset with bit 0 cleared, and `rsp_hi` carries the word with bit 0 set. No memory transaction takes place.
- R3: The request port:
  - `req_valid` and the request fields stay stable until `rsp_valid`.
  - On a read miss the line is fetched with four memory reads at word offsets 0, 1, 2, 3 in that order, and only then does the response come back.
  - Each memory word is one handshake: `mem_req` stays high with a stable address until `mem_ack` has been high for one cycle.
  - The word address is {tag, set, offset}, with a 2-bit offset and a 2-bit set field in the low bits.
- R4: A write-back store (`req_wthru`=0) that hits updates the word and marks the line dirty. It produces no memory write.
- R5: Eviction of a dirty line writes its four words back to memory (offsets 0 to 3) before the refill begins. Eviction of a clean line writes nothing.
- R6: A write-through store (`req_wthru`=1) that hits updates the cached word, sends exactly one memory write, and leaves the dirty flag unchanged, so a line that was clean is later evicted without a write.
- R7: A write-through store that misses sends exactly one memory write and allocates no line. A later read of that address misses.
- R8: A write-back store that misses refills the line and then applies the store to it, so the stored word and the fetched words of that line can then be read with hits.
- R9: When the addressed set has an invalid way, the lowest-numbered invalid way is filled, whatever replacement mode is selected.
- R10: With `repl_random`=0, a full set uses the victim way named by one 2-bit pointer shared by all sets. The pointer is 0 after reset and advances by one, wrapping, after every fill that replaced a valid line, whichever set that was.
- R11: With `repl_random`=1, a full set takes its victim from the low bits of a free-running LFSR, and the new line is resident after the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repl_random | input | 1 | 1 selects LFSR victim choice, 0 selects the shared round-robin pointer |
| req_valid | input | 1 | Request present; held until rsp_valid |
| req_write | input | 1 | 1 for a store, 0 for a read |
| req_wthru | input | 1 | Write policy of the access: 1 write-through, 0 write-back |
| req_addr | input | 16 | Word address {tag, set, offset} |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_lo | output | 32 | Even word of the addressed pair (reads) |
| rsp_hi | output | 32 | Odd word of the addressed pair (reads) |
| mem_req | output | 1 | Memory word transaction request |
| mem_we | output | 1 | 1 memory write, 0 memory read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current memory word |
| mem_rdata | input | 32 | Read data, valid in the acknowledge cycle |

## Verification
The assertions assume a well-behaved requester and memory. The requester keeps `req_addr` and the other request fields steady from the cycle a request is taken until `rsp_valid`. The memory returns `mem_ack` as a single-cycle pulse and only while `mem_req` is high. The bench holds each request from a falling edge until it sees the response pulse, then drops `req_valid` on that same falling edge. Its memory model acknowledges each word one cycle after the request rises and then drops the acknowledge for at least a cycle, so the controller is never offered a back-to-back acknowledge that it did not ask for.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int unsigned DEF_WAYS       = 4;
    localparam int unsigned DEF_SETS       = 4;
    localparam int unsigned DEF_LINE_WORDS = 4;
    localparam int unsigned DEF_ADDR_W     = 16;
    localparam int unsigned DEF_DATA_W     = 32;
    localparam int unsigned LFSR_W         = 8;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 8'hA5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_DONE
    } ctl_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } line_flags_t;

    // maximal-length 8-bit LFSR, taps 8,6,5,4
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import cache_pkg::*;
#(
    parameter  int WAYS  = DEF_WAYS,
    parameter  int SETS  = DEF_SETS,
    parameter  int TAG_W = 12,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [IDX_W-1:0]               look_set,
    input  logic [TAG_W-1:0]               look_tag,
    output logic [WAYS-1:0]                hit_vec,
    output logic [WAYS-1:0]                valid_vec,
    output logic [WAYS-1:0]                dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]     way_tag,
    input  logic                           upd_en,
    input  logic [WAY_W-1:0]               upd_way,
    input  line_flags_t                    upd_flags,
    input  logic [TAG_W-1:0]               upd_tag
);

    line_flags_t [SETS-1:0][WAYS-1:0]      flags_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            tag_q   <= '0;
        end else if (upd_en) begin
            flags_q[look_set][upd_way] <= upd_flags;
            tag_q[look_set][upd_way]   <= upd_tag;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign valid_vec[w] = flags_q[look_set][w].valid;
        assign dirty_vec[w] = flags_q[look_set][w].dirty;
        assign way_tag[w]   = tag_q[look_set][w];
        assign hit_vec[w]   = flags_q[look_set][w].valid && (tag_q[look_set][w] == look_tag);
    end

    // R3: a tag is only ever filled on a miss, so at most one way matches
    a_r3_single_hit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R6: only a fill or a write-back store hit touches the flags; a dirty line never loses valid
    a_r6_dirty_implies_valid: assert property (@(posedge clk) disable iff (rst)
        ((dirty_vec & ~valid_vec) == '0));

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store
    import cache_pkg::*;
#(
    parameter  int WAYS       = DEF_WAYS,
    parameter  int SETS       = DEF_SETS,
    parameter  int LINE_WORDS = DEF_LINE_WORDS,
    parameter  int DATA_W     = DEF_DATA_W,
    localparam int IDX_W      = $clog2(SETS),
    localparam int WAY_W      = $clog2(WAYS),
    localparam int OFF_W      = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  sel_set,
    input  logic [WAY_W-1:0]  pair_way,
    input  logic [OFF_W-1:0]  pair_word,
    output logic [DATA_W-1:0] pair_lo,
    output logic [DATA_W-1:0] pair_hi,
    input  logic [WAY_W-1:0]  ev_way,
    input  logic [OFF_W-1:0]  ev_word,
    output logic [DATA_W-1:0] ev_data,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data
);

    logic [SETS-1:0][WAYS-1:0][LINE_WORDS-1:0][DATA_W-1:0] words_q;
    logic [OFF_W-1:0] lo_idx;
    logic [OFF_W-1:0] hi_idx;

    assign lo_idx  = pair_word & ~OFF_W'(1);
    assign hi_idx  = pair_word |  OFF_W'(1);
    assign pair_lo = words_q[sel_set][pair_way][lo_idx];
    assign pair_hi = words_q[sel_set][pair_way][hi_idx];
    assign ev_data = words_q[sel_set][ev_way][ev_word];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[sel_set][wr_way][wr_word] <= wr_data;
        end
    end

endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick
    import cache_pkg::*;
#(
    parameter  int WAYS  = DEF_WAYS,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             random_mode,
    input  logic [WAYS-1:0]  valid_vec,
    input  logic             advance,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_live
);

    logic [WAY_W-1:0]  rr_q;
    logic [LFSR_W-1:0] lfsr_q;
    logic              free_found;
    logic [WAY_W-1:0]  free_way;

    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
    end

    assign victim_live = !free_found;
    assign victim_way  = free_found  ? free_way :
                         random_mode ? lfsr_q[WAY_W-1:0] : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q   <= '0;
            lfsr_q <= LFSR_SEED;
        end else begin
            lfsr_q <= lfsr_step(lfsr_q);
            if (advance) begin
                rr_q <= rr_q + 1'b1;
            end
        end
    end

    // R9: a set with a free way never evicts a valid line
    a_r9_free_first: assert property (@(posedge clk) disable iff (rst)
        (valid_vec != '1) |-> !valid_vec[victim_way]);

    // R11: the LFSR never locks up at zero
    a_r11_lfsr_alive: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

endmodule

// File: rtl/set_assoc_cache.sv
module set_assoc_cache
    import cache_pkg::*;
#(
    parameter  int WAYS       = DEF_WAYS,
    parameter  int SETS       = DEF_SETS,
    parameter  int LINE_WORDS = DEF_LINE_WORDS,
    parameter  int ADDR_W     = DEF_ADDR_W,
    parameter  int DATA_W     = DEF_DATA_W,
    localparam int OFF_W      = $clog2(LINE_WORDS),
    localparam int IDX_W      = $clog2(SETS),
    localparam int WAY_W      = $clog2(WAYS),
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              repl_random,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wthru,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_lo,
    output logic [DATA_W-1:0] rsp_hi,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(LINE_WORDS - 1);

    ctl_state_e         st_q, st_d;
    logic [WAY_W-1:0]   vic_q;
    logic               repl_q;
    logic [OFF_W-1:0]   wcnt_q;
    logic [DATA_W-1:0]  rsp_lo_q, rsp_hi_q;

    logic [OFF_W-1:0]   req_off;
    logic [IDX_W-1:0]   req_set;
    logic [TAG_W-1:0]   req_tag;

    logic [WAYS-1:0]             hit_vec, valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic                        hit_any;
    logic [WAY_W-1:0]            hit_way;

    logic               upd_en;
    logic [WAY_W-1:0]   upd_way;
    line_flags_t        upd_flags;
    logic               dwr_en;
    logic [WAY_W-1:0]   dwr_way;
    logic [OFF_W-1:0]   dwr_word;
    logic [DATA_W-1:0]  dwr_data;
    logic [DATA_W-1:0]  pair_lo, pair_hi, ev_data;

    logic               advance;
    logic [WAY_W-1:0]   victim_way;
    logic               victim_live;
    logic               take_miss;
    logic               load_rsp;
    logic               last_word;

    assign req_off = req_addr[OFF_W-1:0];
    assign req_set = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

    cache_tag_store #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .look_set  (req_set),
        .look_tag  (req_tag),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .way_tag   (way_tag),
        .upd_en    (upd_en),
        .upd_way   (upd_way),
        .upd_flags (upd_flags),
        .upd_tag   (req_tag)
    );

    cache_line_store #(
        .WAYS       (WAYS),
        .SETS       (SETS),
        .LINE_WORDS (LINE_WORDS),
        .DATA_W     (DATA_W)
    ) u_lines (
        .clk       (clk),
        .sel_set   (req_set),
        .pair_way  (hit_way),
        .pair_word (req_off),
        .pair_lo   (pair_lo),
        .pair_hi   (pair_hi),
        .ev_way    (vic_q),
        .ev_word   (wcnt_q),
        .ev_data   (ev_data),
        .wr_en     (dwr_en),
        .wr_way    (dwr_way),
        .wr_word   (dwr_word),
        .wr_data   (dwr_data)
    );

    cache_victim_pick #(
        .WAYS (WAYS)
    ) u_victim (
        .clk         (clk),
        .rst         (rst),
        .random_mode (repl_random),
        .valid_vec   (valid_vec),
        .advance     (advance),
        .victim_way  (victim_way),
        .victim_live (victim_live)
    );

    always_comb begin
        hit_any = |hit_vec;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    assign last_word = (wcnt_q == LAST_WORD);

    always_comb begin
        st_d      = st_q;
        upd_en    = 1'b0;
        upd_way   = hit_way;
        upd_flags = '{valid: 1'b1, dirty: 1'b1};
        dwr_en    = 1'b0;
        dwr_way   = hit_way;
        dwr_word  = req_off;
        dwr_data  = req_wdata;
        advance   = 1'b0;
        take_miss = 1'b0;
        load_rsp  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (hit_any) begin
                        if (req_write) begin
                            dwr_en = 1'b1;
                            upd_en = !req_wthru;
                            st_d   = req_wthru ? ST_WTHRU : ST_DONE;
                        end else begin
                            load_rsp = 1'b1;
                            st_d     = ST_DONE;
                        end
                    end else if (req_write && req_wthru) begin
                        st_d = ST_WTHRU;
                    end else begin
                        take_miss = 1'b1;
                        st_d = (valid_vec[victim_way] && dirty_vec[victim_way]) ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {way_tag[vic_q], req_set, wcnt_q};
                mem_wdata = ev_data;
                if (mem_ack && last_word) begin
                    st_d = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, req_set, wcnt_q};
                if (mem_ack) begin
                    dwr_en   = 1'b1;
                    dwr_way  = vic_q;
                    dwr_word = wcnt_q;
                    dwr_data = mem_rdata;
                    if (last_word) begin
                        upd_en    = 1'b1;
                        upd_way   = vic_q;
                        upd_flags = '{valid: 1'b1, dirty: 1'b0};
                        advance   = repl_q;
                        st_d      = ST_IDLE;
                    end
                end
            end
            ST_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    st_d = ST_DONE;
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            vic_q    <= '0;
            repl_q   <= 1'b0;
            wcnt_q   <= '0;
            rsp_lo_q <= '0;
            rsp_hi_q <= '0;
        end else begin
            st_q <= st_d;
            if (take_miss) begin
                vic_q  <= victim_way;
                repl_q <= victim_live;
                wcnt_q <= '0;
            end else if ((st_q == ST_EVICT || st_q == ST_FILL) && mem_ack) begin
                wcnt_q <= wcnt_q + 1'b1;
            end
            if (load_rsp) begin
                rsp_lo_q <= pair_lo;
                rsp_hi_q <= pair_hi;
            end
        end
    end

    assign rsp_valid = (st_q == ST_DONE);
    assign rsp_lo    = rsp_lo_q;
    assign rsp_hi    = rsp_hi_q;

    // R3: a memory word stays posted until acknowledged
    a_r3_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: every refill starts at word offset 0
    a_r3_fill_from_zero: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FILL && $past(st_q) != ST_FILL) |-> (mem_addr[OFF_W-1:0] == '0));

    // R3: the requester holds its address while a request is in flight
    a_r3_req_stable: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && st_q != ST_DONE) |-> (req_valid && $stable(req_addr)));

    // R2: completion is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R5: a write-back burst is always followed by the refill
    a_r5_evict_then_fill: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EVICT && mem_ack && last_word) |=> (st_q == ST_FILL && mem_req && !mem_we));

endmodule

// File: tb/test_set_assoc_cache.sv
module test_set_assoc_cache;

    typedef struct packed {
        logic        wr;
        logic        wt;
        logic [15:0] addr;
        logic [31:0] data;
        logic        chk;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [3:0]  nrd;
        logic [3:0]  nwr;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,16'h000,32'h0,        1'b1,32'h10000000,32'h10000001,4'd4,4'd0,8'd3},  // R3 cold miss
        '{1'b0,1'b0,16'h003,32'h0,        1'b1,32'h10000002,32'h10000003,4'd0,4'd0,8'd2},  // R2 pair hit
        '{1'b1,1'b0,16'h001,32'hDEAD0001, 1'b0,32'h0,32'h0,            4'd0,4'd0,8'd4},  // R4 wb store hit
        '{1'b0,1'b0,16'h000,32'h0,        1'b1,32'h10000000,32'hDEAD0001,4'd0,4'd0,8'd4},  // R4
        '{1'b1,1'b1,16'h002,32'hBEEF0002, 1'b0,32'h0,32'h0,            4'd0,4'd1,8'd6},  // R6 wt hit
        '{1'b0,1'b0,16'h002,32'h0,        1'b1,32'hBEEF0002,32'h10000003,4'd0,4'd0,8'd6},  // R6
        '{1'b1,1'b1,16'h104,32'hCAFE0104, 1'b0,32'h0,32'h0,            4'd0,4'd1,8'd7},  // R7 wt miss
        '{1'b0,1'b0,16'h104,32'h0,        1'b1,32'hCAFE0104,32'h10000105,4'd4,4'd0,8'd7},  // R7 no allocate
        '{1'b0,1'b0,16'h010,32'h0,        1'b1,32'h10000010,32'h10000011,4'd4,4'd0,8'd9},  // R9
        '{1'b0,1'b0,16'h020,32'h0,        1'b1,32'h10000020,32'h10000021,4'd4,4'd0,8'd9},  // R9
        '{1'b0,1'b0,16'h030,32'h0,        1'b1,32'h10000030,32'h10000031,4'd4,4'd0,8'd9},  // R9
        '{1'b0,1'b0,16'h000,32'h0,        1'b1,32'h10000000,32'hDEAD0001,4'd0,4'd0,8'd9},  // R9 all four kept
        '{1'b0,1'b0,16'h014,32'h0,        1'b1,32'h10000014,32'h10000015,4'd4,4'd0,8'd9},  // R9
        '{1'b0,1'b0,16'h024,32'h0,        1'b1,32'h10000024,32'h10000025,4'd4,4'd0,8'd9},  // R9
        '{1'b0,1'b0,16'h034,32'h0,        1'b1,32'h10000034,32'h10000035,4'd4,4'd0,8'd9},  // R9
        '{1'b0,1'b0,16'h040,32'h0,        1'b1,32'h10000040,32'h10000041,4'd4,4'd4,8'd5},  // R5 dirty victim way0
        '{1'b0,1'b0,16'h144,32'h0,        1'b1,32'h10000144,32'h10000145,4'd4,4'd0,8'd10}, // R10 set1 way1
        '{1'b0,1'b0,16'h104,32'h0,        1'b1,32'hCAFE0104,32'h10000105,4'd0,4'd0,8'd10}, // R10 way0 kept
        '{1'b0,1'b0,16'h010,32'h0,        1'b1,32'h10000010,32'h10000011,4'd0,4'd0,8'd10}, // R10
        '{1'b1,1'b1,16'h011,32'h11110011, 1'b0,32'h0,32'h0,            4'd0,4'd1,8'd6},  // R6 wt on clean line
        '{1'b0,1'b0,16'h014,32'h0,        1'b1,32'h10000014,32'h10000015,4'd4,4'd0,8'd10}, // R10 evicted earlier
        '{1'b0,1'b0,16'h001,32'h0,        1'b1,32'h10000000,32'hDEAD0001,4'd4,4'd0,8'd5},  // R5 written back data
        '{1'b0,1'b0,16'h002,32'h0,        1'b1,32'hBEEF0002,32'h10000003,4'd0,4'd0,8'd5},  // R5
        '{1'b0,1'b0,16'h050,32'h0,        1'b1,32'h10000050,32'h10000051,4'd4,4'd0,8'd10}, // R10 wrap to way0
        '{1'b0,1'b0,16'h060,32'h0,        1'b1,32'h10000060,32'h10000061,4'd4,4'd0,8'd6},  // R6 clean evict
        '{1'b0,1'b0,16'h010,32'h0,        1'b1,32'h10000010,32'h11110011,4'd4,4'd0,8'd6},  // R6
        '{1'b1,1'b0,16'h0A1,32'h555500A1, 1'b0,32'h0,32'h0,            4'd4,4'd0,8'd8},  // R8 allocate
        '{1'b0,1'b0,16'h0A0,32'h0,        1'b1,32'h100000A0,32'h555500A1,4'd0,4'd0,8'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        repl_random = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wthru = 1'b0;
    logic [15:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_lo, rsp_hi;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    int total = 0;
    int bad   = 0;
    int n_rd  = 0;
    int n_wr  = 0;
    logic [31:0] mem [1024];

    always #2.5 clk = ~clk;

    set_assoc_cache i_set_assoc_cache (
        .clk         (clk),
        .rst         (rst),
        .repl_random (repl_random),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_wthru   (req_wthru),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_lo      (rsp_lo),
        .rsp_hi      (rsp_hi),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 1024; i++) mem[i] <= 32'h1000_0000 | 32'(i);
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[9:0]] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                mem_rdata <= mem[mem_addr[9:0]];
                n_rd <= n_rd + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic wt, input logic [15:0] a, input logic [31:0] d,
                         output logic [31:0] lo, output logic [31:0] hi, output int drd, output int dwr);
        int rd0, wr0;
        @(negedge clk);
        rd0 = n_rd;
        wr0 = n_wr;
        req_valid = 1'b1;
        req_write = wr;
        req_wthru = wt;
        req_addr  = a;
        req_wdata = d;
        do @(negedge clk); while (!rsp_valid);
        lo  = rsp_lo;
        hi  = rsp_hi;
        drd = n_rd - rd0;
        dwr = n_wr - wr0;
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] lo, hi;
        int drd, dwr;
        string tg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        check("R1 mem_req in reset", 32'(mem_req), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R1 mem_req after reset", 32'(mem_req), 32'd0);

        for (int v = 0; v < NV; v++) begin
            do_op(VECS[v].wr, VECS[v].wt, VECS[v].addr, VECS[v].data, lo, hi, drd, dwr);
            tg = $sformatf("R%0d vec%0d", VECS[v].req, v);
            if (VECS[v].chk) begin
                check({tg, " lo"}, lo, VECS[v].lo);
                check({tg, " hi"}, hi, VECS[v].hi);
            end
            check({tg, " mem reads"},  32'(drd), 32'(VECS[v].nrd));
            check({tg, " mem writes"}, 32'(dwr), 32'(VECS[v].nwr));
        end

        // R5: memory image after the dirty write-back
        check("R5 mem word1", mem[1], 32'hDEAD0001);
        check("R5 mem word2", mem[2], 32'hBEEF0002);

        // R11 with R9: random mode still fills free ways first in set 2
        repl_random = 1'b1;
        for (int t = 0; t < 4; t++) begin
            do_op(1'b0, 1'b0, 16'(16'h008 + 16'(t * 16)), 32'h0, lo, hi, drd, dwr);
            check("R9 random-mode cold fill reads", 32'(drd), 32'd4);
        end
        for (int t = 0; t < 4; t++) begin
            do_op(1'b0, 1'b0, 16'(16'h008 + 16'(t * 16)), 32'h0, lo, hi, drd, dwr);
            check("R9 random-mode resident", 32'(drd), 32'd0);
        end
        do_op(1'b0, 1'b0, 16'h048, 32'h0, lo, hi, drd, dwr);
        check("R11 random victim refill", 32'(drd), 32'd4);
        check("R11 refill lo", lo, 32'h10000048);
        do_op(1'b0, 1'b0, 16'h049, 32'h0, lo, hi, drd, dwr);
        check("R11 new line resident", 32'(drd), 32'd0);
        check("R11 hit hi", hi, 32'h10000049);

        // R1: reset again, everything misses
        @(negedge clk);
        rst = 1'b1;
        repl_random = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        do_op(1'b0, 1'b0, 16'h000, 32'h0, lo, hi, drd, dwr);
        check("R1 miss after reset", 32'(drd), 32'd4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule